// File: doc/BRIEF.md
# Indexed Bank Configuration Port with Auto-Advance

This block gives a host access to a file of sixteen 16-bit bank configuration registers through a single data port. A small index register chooses which entry the port reaches. Every port access moves the index on by one, whether it is a read, a write or both in the same cycle. A host can therefore load or dump the whole configuration by accessing one port address over and over. The host can also load the index directly through a separate pointer strobe, and it can read the index back.

The register file holds a base address and a select mask for each of four banks, each value split into a low and a high half. The index interleaves low and high halves bank by bank. The address halves come first and the mask halves follow. Each bank's full 32-bit address and mask are exported continuously to the bank decode logic that uses them.

Top module: `bank_cfg_port`

## Requirements
- R1: `port_rdata` always presents the register selected by the current index `ptr_q`, with no clock delay.
- R2: A cycle in which `port_rd` or `port_wr` (or both) is high counts as one access. At the next rising edge the index goes up by exactly one, unless `ptr_wr` is also high. A cycle with no access and no pointer write leaves the index unchanged.
- R3: While `rst_n` is low, the index is 0 and all sixteen registers are 0, so every exported address and mask is 0.
- R4: An access made at index 15 wraps the index to 0.
- R5: When `ptr_wr` is high, `ptr_q` takes the value of `ptr_wdata` at the next edge and does not advance. A port access in that same cycle uses the index as it stood before the load.
- R6: A port write changes only the register at the current index. The exported values change only in cycles that contain a port write.
- R7: Index 2b holds the low half and index 2b+1 the high half of the base address of bank b, for b = 0..3.
- R8: Index 8+2b holds the low half and index 9+2b the high half of the select mask of bank b.
- R9: `bank_addr[32b+31:32b]` is {high half, low half} of bank b's address. `bank_mask` is built the same way from the mask registers.
- R10: A read does not change any register. When read and write are both high, the read shows the old contents and the write lands after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr | input | 1 | Load the index from `ptr_wdata` |
| ptr_wdata | input | 4 | New index value |
| ptr_q | output | 4 | Current index |
| port_rd | input | 1 | Data port read access |
| port_wr | input | 1 | Data port write access |
| port_wdata | input | 16 | Data port write value |
| port_rdata | output | 16 | Register at the current index |
| bank_addr | output | 128 | Four 32-bit bank base addresses, bank 0 in the low bits |
| bank_mask | output | 128 | Four 32-bit bank select masks, bank 0 in the low bits |

## Verification
The port is driven with several patterns:
- A full 16-access read burst from reset, and a full 16-access write burst with distinct values. Together these confirm the wrap and the low/high and address/mask interleave, because each exported half must match the value written at its own index.
- A second read burst, which must not disturb the exported values.
- A lone write after a direct pointer load, which shows that only one half of one bank moves.
- A pointer load in the same cycle as a write, which separates the old index (where the write lands) from the new one (where the index ends).
- A combined read-and-write cycle, which shows that the old data is returned and that the index advances only once.

// File: rtl/bank_cfg_pkg.sv
package bank_cfg_pkg;

   // Register-file slot of one half of a bank value: {is_mask, bank, is_high}
   function automatic int unsigned cfg_slot(input int unsigned nbanks,
                                            input int unsigned bank,
                                            input int unsigned is_mask,
                                            input int unsigned is_high);
      return is_mask * 2 * nbanks + bank * 2 + is_high;
   endfunction

endpackage

// File: rtl/bank_idx_ptr.sv
module bank_idx_ptr #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             advance,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx <= '0;
      else if (load)    idx <= load_val;
      else if (advance) idx <= idx + STEP;   // natural wrap at 2**IDX_W
   end

endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           idx,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   logic [DATA_W-1:0] mem [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (wr_en && (idx == IDX_W'(i)))
            mem[i] <= wr_data;
      end
      assign regs_flat[i*DATA_W +: DATA_W] = mem[i];
   end

   assign rd_data = mem[idx];

endmodule

// File: rtl/bank_export.sv
module bank_export #(
   parameter int DATA_W    = 16,
   parameter int NUM_BANKS = 4,
   parameter int NUM_REGS  = 16
) (
   input  logic [NUM_REGS*DATA_W-1:0]    regs_flat,
   output logic [NUM_BANKS*2*DATA_W-1:0] addr_flat,
   output logic [NUM_BANKS*2*DATA_W-1:0] mask_flat
);

   import bank_cfg_pkg::*;

   localparam int VAL_W = 2 * DATA_W;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int A_LO = cfg_slot(NUM_BANKS, b, 0, 0);
      localparam int A_HI = cfg_slot(NUM_BANKS, b, 0, 1);
      localparam int M_LO = cfg_slot(NUM_BANKS, b, 1, 0);
      localparam int M_HI = cfg_slot(NUM_BANKS, b, 1, 1);
      assign addr_flat[b*VAL_W +: VAL_W] = {regs_flat[A_HI*DATA_W +: DATA_W],
                                            regs_flat[A_LO*DATA_W +: DATA_W]};
      assign mask_flat[b*VAL_W +: VAL_W] = {regs_flat[M_HI*DATA_W +: DATA_W],
                                            regs_flat[M_LO*DATA_W +: DATA_W]};
   end

endmodule

// File: rtl/bank_cfg_port.sv
module bank_cfg_port #(
   parameter int DATA_W    = 16,
   parameter int NUM_BANKS = 4,
   parameter int NUM_REGS  = 4 * NUM_BANKS,
   parameter int IDX_W     = $clog2(NUM_REGS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ptr_wr,
   input  logic [IDX_W-1:0]              ptr_wdata,
   output logic [IDX_W-1:0]              ptr_q,
   input  logic                          port_rd,
   input  logic                          port_wr,
   input  logic [DATA_W-1:0]             port_wdata,
   output logic [DATA_W-1:0]             port_rdata,
   output logic [NUM_BANKS*2*DATA_W-1:0] bank_addr,
   output logic [NUM_BANKS*2*DATA_W-1:0] bank_mask
);

   initial begin
      if (DATA_W < 1)
         $fatal(1, "bank_cfg_port: DATA_W must be positive");
      if (NUM_BANKS < 1 || (NUM_BANKS & (NUM_BANKS - 1)) != 0)
         $fatal(1, "bank_cfg_port: NUM_BANKS must be a power of two");
      if (NUM_REGS != 4 * NUM_BANKS || (1 << IDX_W) != NUM_REGS)
         $fatal(1, "bank_cfg_port: index width does not cover the register file exactly");
   end

   logic                       access;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;

   assign access = port_rd | port_wr;

   bank_idx_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_wr),
      .load_val (ptr_wdata),
      .advance  (access),
      .idx      (ptr_q)
   );

   bank_reg_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (port_wr),
      .idx       (ptr_q),
      .wr_data   (port_wdata),
      .rd_data   (port_rdata),
      .regs_flat (regs_flat)
   );

   bank_export #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .NUM_REGS(NUM_REGS)) u_exp (
      .regs_flat (regs_flat),
      .addr_flat (bank_addr),
      .mask_flat (bank_mask)
   );

endmodule

// File: rtl/bank_cfg_port_chk.sv
module bank_cfg_port_chk #(
   parameter int DATA_W    = 16,
   parameter int NUM_BANKS = 4,
   parameter int IDX_W     = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          ptr_wr,
   input logic [IDX_W-1:0]              ptr_wdata,
   input logic [IDX_W-1:0]              ptr_q,
   input logic                          port_rd,
   input logic                          port_wr,
   input logic [NUM_BANKS*2*DATA_W-1:0] bank_addr,
   input logic [NUM_BANKS*2*DATA_W-1:0] bank_mask
);

   assert_reset_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ptr_q == '0));

   assert_access_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptr_wr && (port_rd || port_wr)) |=> (ptr_q == IDX_W'($past(ptr_q) + 1'b1)));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptr_wr && !port_rd && !port_wr) |=> $stable(ptr_q));

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptr_wr && port_rd && (ptr_q == '1)) |=> (ptr_q == '0));

   assert_ptr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |=> (ptr_q == $past(ptr_wdata)));

   assert_export_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !port_wr |=> ($stable(bank_addr) && $stable(bank_mask)));

endmodule

bind bank_cfg_port bank_cfg_port_chk #(
   .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
   .ptr_q(ptr_q), .port_rd(port_rd), .port_wr(port_wr),
   .bank_addr(bank_addr), .bank_mask(bank_mask)
);

// File: tb/bank_cfg_port_tb_top.sv
`timescale 1ns/1ps
module bank_cfg_port_tb_top;

   localparam int DW = 16;
   localparam int NB = 4;
   localparam int NR = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ptr_wr = 1'b0;
   logic [3:0]    ptr_wdata = '0;
   logic [3:0]    ptr_q;
   logic          port_rd = 1'b0;
   logic          port_wr = 1'b0;
   logic [DW-1:0] port_wdata = '0;
   logic [DW-1:0] port_rdata;
   logic [NB*32-1:0] bank_addr, bank_mask;

   int n_chk  = 0;
   int n_fail = 0;

   logic [DW-1:0] model [NR];
   logic [3:0]    m_idx;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #5 clk = ~clk;

   bank_cfg_port dut_i (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
      .ptr_q(ptr_q), .port_rd(port_rd), .port_wr(port_wr),
      .port_wdata(port_wdata), .port_rdata(port_rdata),
      .bank_addr(bank_addr), .bank_mask(bank_mask)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares every read cycle with the scoreboard
   initial forever begin
      @(negedge clk);
      #2;
      if (port_rd) begin
         if (exp_q.size() == 0) chk("R1 scoreboard empty", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), {16'h0, port_rdata}, {16'h0, exp_q.pop_front()});
      end
   end

   // driver: one cycle per call, inputs set at the falling edge
   task automatic cyc(input logic rd, input logic wr, input logic [DW-1:0] wd,
                      input logic pw, input logic [3:0] pv, input string tag);
      @(negedge clk);
      port_rd = rd; port_wr = wr; port_wdata = wd; ptr_wr = pw; ptr_wdata = pv;
      if (rd) begin exp_q.push_back(model[m_idx]); tag_q.push_back(tag); end
      if (wr) model[m_idx] = wd;
      if (pw) m_idx = pv;
      else if (rd || wr) m_idx = m_idx + 4'd1;
      @(negedge clk);
      port_rd = 0; port_wr = 0; ptr_wr = 0;
      #1;
   endtask

   task automatic chk_exports(input string tag);
      for (int b = 0; b < NB; b++) begin
         chk({tag, " R7 R9 addr"}, bank_addr[b*32 +: 32], {model[2*b+1], model[2*b]});
         chk({tag, " R8 R9 mask"}, bank_mask[b*32 +: 32], {model[9+2*b], model[8+2*b]});
      end
   endtask

   initial begin
      #200000;
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) model[i] = '0;
      m_idx = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R3 reset index", {28'h0, ptr_q}, 32'h0);
      chk("R3 reset addr", bank_addr[31:0] | bank_addr[127:96], 32'h0);
      chk("R3 reset mask", bank_mask[63:32] | bank_mask[95:64], 32'h0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NR; i++) cyc(1, 0, '0, 0, '0, "R3 R1 read zero after reset");
      chk("R4 wrap after read burst", {28'h0, ptr_q}, 32'h0);

      for (int i = 0; i < NR; i++)
         cyc(0, 1, DW'(16'h1000 + i * 16'h0111 + (i << 12)), 0, '0, "");
      chk("R4 wrap after write burst", {28'h0, ptr_q}, 32'h0);
      chk_exports("burst");

      for (int i = 0; i < NR; i++) cyc(1, 0, '0, 0, '0, "R1 R10 read back");
      chk_exports("R10 after reads");

      cyc(0, 0, '0, 1, 4'd5, "");
      chk("R5 pointer load", {28'h0, ptr_q}, 32'd5);
      repeat (3) @(negedge clk);
      chk("R2 idle holds index", {28'h0, ptr_q}, 32'd5);

      cyc(0, 1, 16'hBEEF, 0, '0, "");
      chk("R6 single write index", {28'h0, ptr_q}, 32'd6);
      chk_exports("R6 single write");

      cyc(0, 1, 16'h5A5A, 1, 4'd12, "");
      chk("R5 load beats advance", {28'h0, ptr_q}, 32'd12);
      chk_exports("R5 write at old index");

      cyc(1, 1, 16'hC0DE, 0, '0, "R10 read old on rd+wr");
      chk("R2 rd+wr one step", {28'h0, ptr_q}, 32'd13);
      chk_exports("R10 rd+wr write lands");

      cyc(0, 0, '0, 1, 4'd15, "");
      cyc(1, 0, '0, 0, '0, "R1 read index 15");
      chk("R4 wrap from 15", {28'h0, ptr_q}, 32'd0);
      cyc(1, 0, '0, 0, '0, "R1 read index 0 after wrap");

      repeat (2) @(negedge clk);
      chk("R1 scoreboard drained", exp_q.size(), 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule